// File: doc/BRIEF.md
# Switchable Halfband Decimator Chain

This block lowers the sample rate of one real, signed sample stream through a chain of five halfband decimate-by-2 filters. The stages grow in length along the chain (7, 11, 15, 19 and 23 taps). A 5-bit enable field switches each stage in or out on its own, in any combination. The output rate is therefore the input rate divided by 2^N, where N is the number of stages switched in. An enabled stage only sees the samples passed on by the enabled stages ahead of it. It keeps its own even/odd phase and delivers one result for every two samples it takes in.

Each stage uses halfband symmetry. The centre coefficient is exactly one half, and it is applied as a shift. Every other tap at an even distance from the centre is zero. Each nonzero pair of symmetric taps is pre-added and then takes a single multiply. Results are rounded back to the input width and clamped on overflow. A new enable pattern is taken up only when a synchronous clear is pulsed. The same clear empties every delay line and resets every phase, so no stage starts from stale history.

Top module: `hbd_chain`

## Requirements
- R1: Stage k (k = 0..4, chain order, bit k of the enable field) has P = k+2 coefficient pairs and 4P-1 taps. Tap t lies at distance 2j+1 from the centre tap for j = 0..P-1. The coefficient values, in units of 2^-16 and from j = 0 outward, are: k0 {18432,-2048}; k1 {19200,-3200,384}; k2 {19600,-3920,784,-80}; k3 {19800,-4500,1300,-250,34}; k4 {19900,-4800,1600,-500,220,-36}. The centre tap is 32768.
- R2: After a clear, an enabled stage emits a result on every second valid input it receives (the 2nd, 4th, ...). The result is sum(coef × sample) over its delay line, with the newest sample at tap 0 and zeros before the clear, rounded as floor((acc + 32768) / 65536). A constant input therefore passes through with gain 1.
- R3: A result above 2^(W-1)-1 is output as 2^(W-1)-1, and a result below -2^(W-1) is output as -2^(W-1).
- R4: A disabled stage forwards every valid input sample unchanged, one cycle later.
- R5: With N stages enabled, the chain emits exactly one output for every 2^N inputs, for any of the 32 enable patterns. An enabled stage never emits on two consecutive cycles.
- R6: Every stage adds exactly one cycle. An output is valid exactly 5 clock cycles after the input that completes it.
- R7: `stage_en` is captured only while `clr` is high. Changes at any other time have no effect. After reset the captured pattern is 0, meaning all stages bypassed.
- R8: `clr` zeroes every delay line and phase. `out_valid` is low in the cycle after `clr`.
- R9: During and right after reset, `out_valid` is 0 and `out_data` is 0.
- R10: Cycles with `in_valid` low do not advance any stage. A cycle with `in_valid` low is followed by a cycle with no output from the stage it feeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of all stages; loads `stage_en` |
| stage_en | input | 5 | Per-stage enable, bit 0 = first (shortest) stage |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | W (16) | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | W (16) | Signed decimated output sample |

## Verification
Each stage holds one register, so an output appears exactly 5 cycles after the input that completes it, whatever the enable pattern. A directed test checks that `out_valid` is high only at that cycle and low in the cycles either side. For the table-driven streams, the bench captures outputs on falling edges. It compares them in order against a bench-side model only after a 10-cycle drain, which is longer than the 5-cycle latency. Checks on ignored enable changes and on the clear look at the following output stream, not at internal state.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    localparam int HB_STAGES = 5;
    localparam int COEF_FRAC = 16;
    localparam int COEF_W    = 18;

    // Nonzero side coefficient j (0 = next to the centre) for a stage with
    // the given number of symmetric pairs, in units of 2^-COEF_FRAC.
    function automatic int hb_coef(input int pairs, input int j);
        int c;
        c = 0;
        case (pairs)
            2: case (j)
                   0: c = 18432;  1: c = -2048;
                   default: c = 0;
               endcase
            3: case (j)
                   0: c = 19200;  1: c = -3200;  2: c = 384;
                   default: c = 0;
               endcase
            4: case (j)
                   0: c = 19600;  1: c = -3920;  2: c = 784;  3: c = -80;
                   default: c = 0;
               endcase
            5: case (j)
                   0: c = 19800;  1: c = -4500;  2: c = 1300;  3: c = -250;
                   4: c = 34;
                   default: c = 0;
               endcase
            6: case (j)
                   0: c = 19900;  1: c = -4800;  2: c = 1600;  3: c = -500;
                   4: c = 220;    5: c = -36;
                   default: c = 0;
               endcase
            default: c = 0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hbd_round_sat.sv
module hbd_round_sat #(
    parameter int AW   = 40,
    parameter int OW   = 16,
    parameter int FRAC = 16
) (
    input  logic signed [AW-1:0] acc,
    output logic        [OW-1:0] y
);
    localparam logic signed [AW-1:0] BIAS = AW'(1) <<< (FRAC - 1);
    localparam logic signed [AW-1:0] MAXV = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [AW-1:0] MINV = ~MAXV;

    logic signed [AW-1:0] scaled;

    always_comb begin
        scaled = (acc + BIAS) >>> FRAC;
        if (scaled > MAXV)      y = MAXV[OW-1:0];
        else if (scaled < MINV) y = MINV[OW-1:0];
        else                    y = scaled[OW-1:0];
    end
endmodule

// File: rtl/hbd_stage.sv
module hbd_stage
    import hbd_pkg::*;
#(
    parameter int W     = 16,
    parameter int STAGE = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    localparam int PAIRS = STAGE + 2;
    localparam int TAPS  = 4 * PAIRS - 1;
    localparam int CTR   = 2 * PAIRS - 1;
    localparam int ACCW  = W + COEF_W + $clog2(PAIRS + 1) + 2;

    typedef struct packed {
        logic [TAPS-1:0][W-1:0] dl;
        logic                   ph;
        logic                   vld;
        logic [W-1:0]           dout;
    } st_t;

    st_t s_d, s_q;

    logic [TAPS-1:0][W-1:0] line;
    logic signed [ACCW-1:0] acc;
    logic signed [W:0]      pre;
    logic signed [COEF_W-1:0] cf;
    logic [W-1:0]           rnd;

    // delay line as it will look once the current input is shifted in
    always_comb begin
        line[0] = in_data;
        for (int i = 1; i < TAPS; i++) line[i] = s_q.dl[i-1];
    end

    // centre tap is one half: a shift; side pairs pre-added, one multiply each
    always_comb begin
        acc = ACCW'($signed(line[CTR])) <<< (COEF_FRAC - 1);
        pre = '0;
        cf  = '0;
        for (int j = 0; j < PAIRS; j++) begin
            pre = $signed(line[CTR-1-2*j]) + $signed(line[CTR+1+2*j]);
            cf  = COEF_W'(hb_coef(PAIRS, j));
            acc = acc + ACCW'(pre) * ACCW'(cf);
        end
    end

    hbd_round_sat #(.AW(ACCW), .OW(W), .FRAC(COEF_FRAC)) u_rs (
        .acc (acc),
        .y   (rnd)
    );

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (in_valid) begin
            s_d.dl = line;
            if (en) begin
                s_d.ph = ~s_q.ph;
                if (s_q.ph) begin
                    s_d.vld  = 1'b1;
                    s_d.dout = rnd;
                end
            end else begin
                s_d.vld  = 1'b1;
                s_d.dout = in_data;
            end
        end
        if (clr) s_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_data  = s_q.dout;

    AST_BYP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && in_valid && !clr) |=> (out_valid && out_data == $past(in_data))); // R4
    AST_DEC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && out_valid) |=> !out_valid); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
endmodule

// File: rtl/hbd_chain.sv
module hbd_chain
    import hbd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [HB_STAGES-1:0] stage_en,
    input  logic                 in_valid,
    input  logic [W-1:0]         in_data,
    output logic                 out_valid,
    output logic [W-1:0]         out_data
);
    typedef struct packed {
        logic [HB_STAGES-1:0] en;
    } cfg_t;

    cfg_t c_d, c_q;

    logic [HB_STAGES:0]        v;
    logic [HB_STAGES:0][W-1:0] d;

    always_comb begin
        c_d = c_q;
        if (clr) c_d.en = stage_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign v[0] = in_valid;
    assign d[0] = in_data;

    for (genvar k = 0; k < HB_STAGES; k++) begin : g_stage
        hbd_stage #(.W(W), .STAGE(k)) u_st (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .en        (c_q.en[k]),
            .in_valid  (v[k]),
            .in_data   (d[k]),
            .out_valid (v[k+1]),
            .out_data  (d[k+1])
        );
    end

    assign out_valid = v[HB_STAGES];
    assign out_data  = d[HB_STAGES];

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> $stable(c_q.en)); // R7
    AST_CLR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !out_valid); // R8
endmodule

// File: tb/sim_hbd_chain.sv
module sim_hbd_chain;
    localparam int W = 16;
    localparam int NS = 200;

    // {mask[4:0], pattern[2:0], gap[1:0], amp[15:0]}
    // pattern: 0 DC, 1 impulse, 2 overflow motif, 3 ramp, 4 pseudo-random
    localparam logic [25:0] VEC [10] = '{
        {5'b00001, 3'd0, 2'd0, 16'sd1000},
        {5'b00001, 3'd1, 2'd1, 16'sd20000},
        {5'b00001, 3'd2, 2'd0, 16'sd32767},
        {5'b00001, 3'd2, 2'd0, -16'sd32768},
        {5'b10100, 3'd3, 2'd2, 16'sd300},
        {5'b11111, 3'd4, 2'd0, 16'sd20000},
        {5'b01010, 3'd4, 2'd1, 16'sd12000},
        {5'b00000, 3'd3, 2'd0, 16'sd100},
        {5'b11111, 3'd0, 2'd0, -16'sd5000},
        {5'b10000, 3'd1, 2'd0, 16'sd30000}
    };

    logic         clk = 0;
    logic         rst_n = 0;
    logic         clr = 0;
    logic [4:0]   stage_en = '0;
    logic         in_valid = 0;
    logic [W-1:0] in_data = '0;
    logic         out_valid;
    logic [W-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int stim[$];
    int expq[$];
    int got[$];

    always #10 clk = ~clk;

    hbd_chain #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .stage_en(stage_en),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always @(negedge clk)
        if (rst_n && out_valid) got.push_back(int'($signed(out_data)));

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int tb_coef(input int p, input int j);
        int t2[2] = '{18432, -2048};
        int t3[3] = '{19200, -3200, 384};
        int t4[4] = '{19600, -3920, 784, -80};
        int t5[5] = '{19800, -4500, 1300, -250, 34};
        int t6[6] = '{19900, -4800, 1600, -500, 220, -36};
        case (p)
            2: return t2[j];
            3: return t3[j];
            4: return t4[j];
            5: return t5[j];
            default: return t6[j];
        endcase
    endfunction

    function automatic int clamp16(input longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return int'(x);
    endfunction

    function automatic int gen(input int pat, input int amp, input int i);
        int mot[8] = '{0, -1, 0, 1, 1, 1, 0, -1};
        int unsigned h;
        int r;
        case (pat)
            0: return amp;
            1: return (i == 3) ? amp : 0;
            2: return clamp16(longint'(mot[i % 8]) * amp);
            3: return ((i * amp) % 60000) - 30000;
            default: begin
                h = (i + 1) * 32'd1103515245 + 32'd12345;
                r = int'((h >> 8) % (2 * amp + 1));
                return r - amp;
            end
        endcase
    endfunction

    // bench-side model of the cascade on stim -> expq
    task automatic run_model(input logic [4:0] m);
        int cur[$];
        cur = stim;
        for (int s = 0; s < 5; s++) begin
            int nxt[$];
            int dl[23];
            int p, c;
            bit ph;
            longint acc;
            if (!m[s]) continue;
            p = s + 2;
            c = 2 * p - 1;
            ph = 0;
            foreach (dl[k]) dl[k] = 0;
            foreach (cur[n]) begin
                for (int k = 22; k > 0; k--) dl[k] = dl[k-1];
                dl[0] = cur[n];
                if (ph) begin
                    acc = longint'(dl[c]) * 32768;
                    for (int j = 0; j < p; j++)
                        acc += longint'(tb_coef(p, j)) * (dl[c-1-2*j] + dl[c+1+2*j]);
                    nxt.push_back(clamp16((acc + 32768) >>> 16));
                end
                ph = !ph;
            end
            cur = nxt;
        end
        expq = cur;
    endtask

    task automatic send(input int x, input int gap);
        @(negedge clk);
        in_valid = 1;
        in_data  = W'(x);
        repeat (gap) begin
            @(negedge clk);
            in_valid = 0;
        end
    endtask

    task automatic finish_send();
        @(negedge clk);
        in_valid = 0;
        repeat (10) @(negedge clk);
    endtask

    task automatic do_clr(input logic [4:0] m);
        @(negedge clk);
        stage_en = m;
        clr = 1;
        @(negedge clk);
        clr = 0;
    endtask

    task automatic compare(input string tag);
        chk(got.size() == expq.size(), {tag, " R5 output count"}, got.size(), expq.size());
        foreach (expq[i])
            if (i < got.size()) chk(got[i] == expq[i], tag, got[i], expq[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 0, "R9 out_valid in reset", out_valid, 0);
        chk(out_data == 0, "R9 out_data in reset", out_data, 0);
        rst_n = 1;
        @(negedge clk);
        chk(out_valid == 0, "R9 out_valid after reset", out_valid, 0);

        // R7 reset pattern is full bypass, no clr issued
        got.delete();
        stim.delete();
        for (int i = 0; i < 6; i++) begin
            stim.push_back(i * 111 - 200);
            send(i * 111 - 200, 0);
        end
        finish_send();
        run_model(5'b00000);
        compare("R7 bypass after reset");

        // R6 latency: output exactly 5 cycles after the input
        got.delete();
        @(negedge clk);
        in_valid = 1;
        in_data  = W'(1234);
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            if (k == 1) in_valid = 0;
            chk(out_valid == (k == 5), "R6 latency valid", out_valid, (k == 5));
            if (k == 5) chk($signed(out_data) == 1234, "R6 latency data", $signed(out_data), 1234);
        end

        // vector table
        foreach (VEC[v]) begin
            logic [4:0] m;
            int pat, gap, amp;
            string tag;
            m   = VEC[v][25:21];
            pat = int'(VEC[v][20:18]);
            gap = int'(VEC[v][17:16]);
            amp = int'($signed(VEC[v][15:0]));
            if (pat == 2)              tag = "R3 saturation";
            else if (pat == 1)         tag = "R1 impulse";
            else if (m == 0)           tag = "R4 bypass";
            else if ($countones(m) > 1) tag = "R5 cascade";
            else                       tag = "R2 filter";
            do_clr(m);
            got.delete();
            stim.delete();
            for (int i = 0; i < NS; i++) begin
                stim.push_back(gen(pat, amp, i));
                send(gen(pat, amp, i), gap); // gaps exercise R10
            end
            finish_send();
            run_model(m);
            compare(tag);
        end

        // R7 enable change without clr is ignored
        do_clr(5'b00001);
        @(negedge clk);
        stage_en = 5'b11111;
        got.delete();
        stim.delete();
        for (int i = 0; i < 16; i++) begin
            stim.push_back(700);
            send(700, 0);
        end
        finish_send();
        run_model(5'b00001);
        compare("R7 enable held");

        // R8 clear drops history and phase
        do_clr(5'b00001);
        for (int i = 0; i < 3; i++) send(1000, 0);
        finish_send();
        do_clr(5'b00001);
        got.delete();
        stim.delete();
        stim.push_back(4000);
        stim.push_back(4000);
        send(4000, 0);
        send(4000, 0);
        finish_send();
        run_model(5'b00001);
        compare("R8 clear");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule